// File: doc/BRIEF.md
# Sampled Tri-State Phase-Frequency Detector

This block compares a reference clock with a feedback clock. Both are slow signals that a fast system clock samples. It drives two pulse outputs, `up` and `dn`, which a charge pump downstream consumes. The detector reacts only to rising edges. A reference edge moves the detector one step toward `up`, and a feedback edge moves it one step toward `dn`. When both outputs are high, a reset window of a fixed number of system cycles holds them. Both then clear together. The window must be at least a configured minimum, which stands for the pump's switching time. This keeps the detector free of a dead zone near lock.

While the window runs, a new input edge cannot be taken in. In the baseline mode such an edge is dropped and reported on `blind_edge`. The next edge of the other input then gives an output of the wrong polarity. In compensation mode (`comp_mode` high), an edge that lands in the last `COMP_DLY` cycles of the window is held back. It is applied in the first cycle after the window closes, so the blind part of the window shrinks to `RST_DLY - COMP_DLY` cycles. For correct results, the input period must stay above twice the reset window.

Top module: `sampled_pfd`

## Requirements
- R1: Only a rising edge of `ref_in` or `fb_in` can change the outputs. A falling edge, or a level that stays the same, leaves `up` and `dn` as they were.
- R2: A lone reference edge gives these results: with no output set, `up` is set; with `up` already set, nothing changes; with `dn` set, the reset window opens. A lone feedback edge acts as the mirror image toward `dn`.
- R3: Once `up` and `dn` are both high, they stay high together for exactly `RST_DLY` system cycles and then both drop. Elaboration rejects `RST_DLY` below `MIN_RST_DLY`, and rejects `MIN_RST_DLY` below 1.
- R4: In the baseline mode, a rising edge whose detection falls in a reset-window cycle is discarded. For each such cycle, `blind_edge` is high for one cycle, in the cycle after it. `blind_edge` is never high at any other time.
- R5: After a reference edge has been discarded in the window, the next feedback edge sets `dn` alone, which is the wrong polarity.
- R6: With `comp_mode` high, an edge detected during the final `COMP_DLY` cycles of the window is not flagged. It takes effect in the first cycle after the window. An edge earlier in the window is still discarded and flagged. Elaboration rejects `COMP_DLY` not strictly below `RST_DLY`.
- R7: If both inputs show a rising edge in the same system cycle, the state does not change. In particular, `up` and `dn` never rise in the same cycle.
- R8: Each input passes two synchroniser flops and an edge detector. A rising input sampled at a clock edge shows on `up` or `dn` after the third clock edge, counting that one.
- R9: `rst_n` low clears `up`, `dn` and `blind_edge` at once, without waiting for a clock. Release leaves the detector idle.
- R10: If the reference leads the feedback by d cycles, `up` is high for d+`RST_DLY` cycles and `dn` for `RST_DLY` cycles. A lag of d cycles gives the mirror result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| fb_in | input | 1 | Feedback clock, asynchronous to clk |
| comp_mode | input | 1 | 1 = hold back late edges in the window, 0 = baseline |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| blind_edge | output | 1 | One-cycle flag for an input edge lost in the reset window |

## Verification
Two functions can fall in the same cycle: the close of the reset window and the arrival of a new input edge. The bench provokes this by placing a second reference rise at a chosen offset after the feedback rise. The offset puts the rise either in an early window cycle or in the last window cycle. It runs each placement in both modes. The results are judged from `blind_edge` and from the final polarity of `up` and `dn`. The other clash is two rising edges in the same cycle. The bench drives it both from idle and with `up` already held, and expects no change in either case.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_DN   = 2'd2,
    ST_RST  = 2'd3
  } pfd_state_e;

  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;
  localparam int unsigned NCH    = 2;
endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  for (genvar g = 0; g < W; g++) begin : g_ch
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[g];
    end

    assign rise[g] = lvl[g] & ~prev_q;
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int RST_DLY  = 4,
  parameter int COMP_DLY = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rise,
  input  logic           comp_mode,
  output logic           up,
  output logic           dn,
  output logic           blind_edge
);
  localparam int CW = $clog2(RST_DLY + 1);
  localparam logic [CW-1:0] LAST_CNT   = CW'(RST_DLY - 1);
  localparam logic [CW-1:0] LATE_START = CW'(RST_DLY - COMP_DLY);

  pfd_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [NCH-1:0] pend_q, pend_d;
  logic           blind_q, blind_d;

  logic           in_win;
  logic           late;
  logic [NCH-1:0] defer;
  logic [NCH-1:0] drop;
  logic [NCH-1:0] eff;

  // next-state logic
  always_comb begin
    in_win  = (state_q == ST_RST);
    late    = in_win && comp_mode && (cnt_q >= LATE_START);
    defer   = rise & {NCH{late}};
    drop    = rise & {NCH{in_win}} & ~defer;
    eff     = in_win ? '0 : (rise | pend_q);
    pend_d  = in_win ? (pend_q | defer) : '0;
    blind_d = |drop;
    cnt_d   = in_win ? (cnt_q + 1'b1) : '0;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if      (eff == 2'b01) state_d = ST_UP;
        else if (eff == 2'b10) state_d = ST_DN;
      end
      ST_UP:   if (eff == 2'b10) state_d = ST_RST;
      ST_DN:   if (eff == 2'b01) state_d = ST_RST;
      ST_RST:  if (cnt_q == LAST_CNT) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= '0;
      blind_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      blind_q <= blind_d;
    end
  end

  assign up         = (state_q == ST_UP) || (state_q == ST_RST);
  assign dn         = (state_q == ST_DN) || (state_q == ST_RST);
  assign blind_edge = blind_q;
endmodule

// File: rtl/sampled_pfd.sv
module sampled_pfd
  import pfd_pkg::*;
#(
  parameter int RST_DLY     = 4,
  parameter int MIN_RST_DLY = 3,
  parameter int COMP_DLY    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  input  logic comp_mode,
  output logic up,
  output logic dn,
  output logic blind_edge
);
  if (MIN_RST_DLY < 1) begin : g_bad_min
    $error("sampled_pfd: MIN_RST_DLY must be at least 1");
  end
  if (RST_DLY < MIN_RST_DLY) begin : g_bad_rst
    $error("sampled_pfd: RST_DLY below MIN_RST_DLY leaves a dead zone");
  end
  if ((COMP_DLY < 0) || (COMP_DLY >= RST_DLY)) begin : g_bad_comp
    $error("sampled_pfd: COMP_DLY must lie in [0, RST_DLY)");
  end

  logic [NCH-1:0] raw;
  logic [NCH-1:0] lvl;
  logic [NCH-1:0] rise;

  assign raw[CH_REF] = ref_in;
  assign raw[CH_FB]  = fb_in;

  pfd_sync #(.W(NCH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (lvl)
  );

  pfd_edge #(.W(NCH)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl),
    .rise  (rise)
  );

  pfd_core #(.RST_DLY(RST_DLY), .COMP_DLY(COMP_DLY)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise),
    .comp_mode  (comp_mode),
    .up         (up),
    .dn         (dn),
    .blind_edge (blind_edge)
  );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int RST_DLY = 4
) (
  input logic clk,
  input logic rst_n,
  input logic up,
  input logic dn,
  input logic blind_edge
);
  localparam int RW = $clog2(RST_DLY + 2) + 1;
  localparam logic [RW-1:0] LIM = RW'(RST_DLY);

  logic both;
  logic [RW-1:0] run_q;

  assign both = up && dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (!both)            run_q <= '0;
    else if (run_q != '1)      run_q <= run_q + 1'b1;
  end

  assert_win_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    both |-> (run_q < LIM));

  assert_win_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!both && $past(both)) |-> (run_q == LIM));

  assert_no_twin_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(up) && $rose(dn)));

  assert_blind_after_win_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blind_edge |-> $past(both));

  assert_lone_up_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(up) && !dn) |-> $past(!up && !dn));
endmodule

bind sampled_pfd pfd_checker #(.RST_DLY(RST_DLY)) u_pfd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .up         (up),
  .dn         (dn),
  .blind_edge (blind_edge)
);

// File: tb/test_sampled_pfd.sv
`timescale 1ns/1ps
module test_sampled_pfd;
  localparam int RST_DLY  = 4;
  localparam int COMP_DLY = 2;
  localparam int NV       = 8;
  localparam int NONE     = 1000;

  // lead (ref ahead of fb, in cycles), mode, expected up / dn widths (R10, R7)
  localparam int TAB_D    [NV] = '{3, -2, 1, 0, 6, -5, 0, 2};
  localparam int TAB_C    [NV] = '{0,  0, 1, 0, 1,  1, 1, 0};
  localparam int TAB_UP   [NV] = '{7,  4, 5, 0, 10, 4, 0, 6};
  localparam int TAB_DN   [NV] = '{4,  6, 4, 0, 4,  9, 0, 4};

  logic clk, rst_n, ref_in, fb_in, comp_mode;
  logic up, dn, blind_edge;
  int total, bad;
  bit done;

  sampled_pfd #(.RST_DLY(RST_DLY), .MIN_RST_DLY(3), .COMP_DLY(COMP_DLY)) i_sampled_pfd (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .comp_mode(comp_mode), .up(up), .dn(dn), .blind_edge(blind_edge)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // ref high from r1 except low in [rlo,rhi); fb likewise; counts outputs
  task automatic pulse_seq(input int r1, input int f1, input int rlo, input int rhi,
                           input int flo, input int fhi,
                           output int nup, output int ndn, output int nbl,
                           output int fin_up, output int fin_dn);
    nup = 0; ndn = 0; nbl = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      nup += int'(up);
      ndn += int'(dn);
      nbl += int'(blind_edge);
      ref_in = (i >= r1) && !(i >= rlo && i < rhi);
      fb_in  = (i >= f1) && !(i >= flo && i < fhi);
    end
    @(negedge clk);
    fin_up = int'(up);
    fin_dn = int'(dn);
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int nu, nd, nb, fu, fd;
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0; comp_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 up in reset", int'(up), 0);
    chk("R9 dn in reset", int'(dn), 0);
    chk("R9 blind in reset", int'(blind_edge), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table
    for (int v = 0; v < NV; v++) begin
      comp_mode = TAB_C[v][0];
      if (TAB_D[v] >= 0)
        pulse_seq(0, TAB_D[v], NONE, NONE, NONE, NONE, nu, nd, nb, fu, fd);
      else
        pulse_seq(-TAB_D[v], 0, NONE, NONE, NONE, NONE, nu, nd, nb, fu, fd);
      chk($sformatf("R10 up width row %0d", v), nu, TAB_UP[v]);
      chk($sformatf("R10 dn width row %0d", v), nd, TAB_DN[v]);
      chk($sformatf("R4 no blind row %0d", v), nb, 0);
      chk($sformatf("R3 idle after row %0d", v), fu + fd, 0);
    end

    // R8 latency, R1 falling ignored, R2 UP holds, R7 twin edges, R3 clear
    comp_mode = 1'b0;
    do_reset();
    @(negedge clk); ref_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 up not before third edge", int'(up), 0);
    @(negedge clk);
    chk("R8 up after third edge", int'(up), 1);
    ref_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 up kept after ref fall", int'(up), 1);
    chk("R1 dn low after ref fall", int'(dn), 0);
    ref_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 up stays on second ref edge", int'(up), 1);
    chk("R2 dn low on second ref edge", int'(dn), 0);
    ref_in = 1'b0;
    repeat (3) @(negedge clk);
    ref_in = 1'b1; fb_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 up kept on twin edges", int'(up), 1);
    chk("R7 dn low on twin edges", int'(dn), 0);
    fb_in = 1'b0;
    repeat (3) @(negedge clk);
    fb_in = 1'b1;
    repeat (12) @(negedge clk);
    chk("R3 up clear after window", int'(up), 0);
    chk("R3 dn clear after window", int'(dn), 0);

    // R7 twin edges from idle
    ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(negedge clk);
    ref_in = 1'b1; fb_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 idle up on twin edges", int'(up), 0);
    chk("R7 idle dn on twin edges", int'(dn), 0);

    // R9 asynchronous reset while up
    ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(negedge clk);
    ref_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 up set before reset", int'(up), 1);
    rst_n = 1'b0;
    #1;
    chk("R9 up cleared without clock", int'(up), 0);
    ref_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle after release", int'(up) + int'(dn), 0);

    // R4 / R5: baseline, second ref edge early in window, then fb edge
    comp_mode = 1'b0;
    do_reset();
    pulse_seq(0, 1, 2, 3, 10, 12, nu, nd, nb, fu, fd);
    chk("R4 lost edge flagged", nb, 1);
    chk("R5 wrong polarity dn", fd, 1);
    chk("R5 wrong polarity up", fu, 0);

    // R4 baseline, edge in last window cycle still lost
    do_reset();
    pulse_seq(0, 1, 4, 5, NONE, NONE, nu, nd, nb, fu, fd);
    chk("R4 late edge lost in baseline", nb, 1);
    chk("R4 no up after lost edge", fu, 0);

    // R6 compensation: late edge deferred
    comp_mode = 1'b1;
    do_reset();
    pulse_seq(0, 1, 4, 5, NONE, NONE, nu, nd, nb, fu, fd);
    chk("R6 deferred edge not flagged", nb, 0);
    chk("R6 deferred edge sets up", fu, 1);
    chk("R6 deferred edge dn low", fd, 0);

    // R6 compensation: early edge still lost
    do_reset();
    pulse_seq(0, 1, 2, 3, NONE, NONE, nu, nd, nb, fu, fd);
    chk("R6 early edge flagged", nb, 1);
    chk("R6 early edge no up", fu, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule